// File: doc/BRIEF.md
# Seconds Timekeeper with Alarm

This block keeps wall time as one 47-bit count that advances on each pulse of a 32 kHz time-base strobe. The low 15 bits hold the sub-second fraction and the upper 32 bits hold whole seconds, so the seconds value steps once every 32768 ticks. Software can load a new seconds value, which also zeroes the fraction. It can read the seconds and the fraction, and it can program an alarm that holds whole seconds only.

When the seconds value reaches the programmed alarm, a sticky compare flag is set. It stays set until a write-one-to-clear pulse removes it. An interrupt line is driven while the flag and its enable are both high. No periodic interrupt exists; the alarm is the only time-based event. A wrap of the full count from all ones back to zero produces a one-cycle overflow pulse, which the surrounding security logic can use to enter its failure state. That logic drives a halt input, and the halt input freezes the count so that the moment of the event is preserved.

Top module: `secs_timekeeper`

## Requirements
- R1: After reset, seconds and fraction read 0, the alarm reads all ones (unset), and the compare flag, interrupt and overflow outputs are low.
- R2: Each cycle with `tick_i` high (and no load or halt) adds one to the 47-bit count. The fraction is bits 14..0 and the seconds are bits 46..15, so seconds increase by one when the fraction passes from 32767 to 0.
- R3: A seconds load sets the seconds to the written value and the fraction to 0 in the next cycle. A load wins over a tick in the same cycle, and a load is also accepted while halted.
- R4: While `halt_i` is high, ticks are ignored and the seconds and fraction hold their values.
- R5: An alarm write stores the written seconds value, and that value appears on `alarm_sec_o` in the next cycle.
- R6: The compare flag goes high one cycle after the seconds first become equal to a set alarm, and it stays high while no clear is given.
- R7: A clear pulse drops the flag in the next cycle. If a new match begins in the same cycle as the clear, the flag is set and stays high.
- R8: `irq_o` is high exactly when the compare flag and `irq_en_i` are both high.
- R9: When the count advances from all ones, it wraps to zero, and `ovf_o` is high for exactly that one following cycle.
- R10: The all-ones alarm value is reserved as unset and never sets the flag, even when the seconds are also all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | 32 kHz time-base strobe, one cycle per tick |
| halt_i | input | 1 | Freeze request from the security logic |
| sec_wr_i | input | 1 | Seconds load strobe |
| sec_wdata_i | input | 32 | Seconds value to load |
| alarm_wr_i | input | 1 | Alarm write strobe |
| alarm_wdata_i | input | 32 | Alarm seconds value (all ones = unset) |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the compare flag |
| irq_en_i | input | 1 | Alarm interrupt enable |
| sec_o | output | 32 | Current seconds |
| frac_o | output | 15 | Current fraction of a second |
| alarm_sec_o | output | 32 | Programmed alarm seconds |
| cmp_flag_o | output | 1 | Sticky alarm compare flag |
| irq_o | output | 1 | Alarm interrupt |
| ovf_o | output | 1 | One-cycle count wrap event |

## Verification
The embedded properties check, on every cycle, that a halt holds the count, that a load lands with a zero fraction, that a fraction step leaves the seconds unchanged, that an overflow pulse only ever comes with a zero count, and that the flag is sticky and never set by an unset alarm. The bench's scenarios are needed to show the seconds carry after exactly 32768 ticks, that a real alarm crossing sets the flag, that a set takes priority over a clear in the same cycle, and the full wrap from all ones. Those results come from long tick runs that a behavioural reference model follows cycle by cycle.

// File: rtl/secs_pkg.sv
package secs_pkg;
  // Default split of the 47-bit count.
  localparam int unsigned SECS_FRAC_W_DEF = 15;
  localparam int unsigned SECS_SEC_W_DEF  = 32;
  // Reset synchronizer stages.
  localparam int unsigned SECS_SYNC_STAGES = 2;
endpackage

// File: rtl/secs_rst_sync.sv
module secs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/secs_count.sv
module secs_count #(
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned SEC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              halt_i,
  input  logic              ld_i,
  input  logic [SEC_W-1:0]  ld_sec_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic              ovf_o
);
  localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
  localparam logic [SEC_W-1:0]  SEC_MAX  = '1;

  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic              ovf_q, ovf_d;
  logic              run, frac_wrap, frac_en, sec_en;

  // Next-state logic with written-out clock enables.
  always_comb begin
    run       = adv_i & ~halt_i;
    frac_wrap = (frac_q == FRAC_MAX);
    frac_en   = ld_i | run;
    sec_en    = ld_i | (run & frac_wrap);
    frac_d    = frac_q;
    sec_d     = sec_q;
    ovf_d     = 1'b0;
    if (ld_i) begin
      frac_d = '0;
      sec_d  = ld_sec_i;
    end else if (run) begin
      frac_d = frac_q + FRAC_W'(1);
      if (frac_wrap) begin
        sec_d = sec_q + SEC_W'(1);
        ovf_d = (sec_q == SEC_MAX);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      sec_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (frac_en) frac_q <= frac_d;
      if (sec_en)  sec_q  <= sec_d;
      ovf_q <= ovf_d;
    end
  end

  assign frac_o = frac_q;
  assign sec_o  = sec_q;
  assign ovf_o  = ovf_q;

  // R4: a halt without a load keeps the count still.
  a_r4_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !ld_i) |=> ($stable(frac_q) && $stable(sec_q)));

  // R3: a load lands with a zero fraction.
  a_r3_load_zero_frac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (frac_q == '0 && sec_q == $past(ld_sec_i)));

  // R2: a fraction step below the carry point leaves the seconds alone.
  a_r2_frac_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !halt_i && !ld_i && frac_q != FRAC_MAX)
      |=> (frac_q == $past(frac_q) + FRAC_W'(1) && $stable(sec_q)));

  // R9: an overflow pulse only ever comes with a zero count.
  a_r9_ovf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (frac_q == '0 && sec_q == '0));
endmodule

// File: rtl/secs_alarm.sv
module secs_alarm #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             wr_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic             clr_i,
  input  logic             irq_en_i,
  output logic [SEC_W-1:0] alarm_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [SEC_W-1:0] UNSET = '1;

  logic [SEC_W-1:0] alm_q, alm_d;
  logic             flag_q, flag_d;
  logic             hit_q;
  logic             hit, hit_start;

  always_comb begin
    hit       = (alm_q != UNSET) && (sec_i == alm_q);
    hit_start = hit & ~hit_q;
    flag_d    = hit_start | (flag_q & ~clr_i);
    alm_d     = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q  <= UNSET;
      flag_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      if (wr_i) alm_q <= alm_d;
      flag_q <= flag_d;
      hit_q  <= hit;
    end
  end

  assign alarm_o = alm_q;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q & irq_en_i;

  // R5: a written alarm value is held.
  a_r5_alarm_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (alm_q == $past(wdata_i)));

  // R6: the flag is sticky until cleared.
  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  // R7: a clear with no match drops the flag.
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q);

  // R10: an unset alarm never raises the flag.
  a_r10_unset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_q == UNSET && !flag_q) |=> !flag_q);
endmodule

// File: rtl/secs_timekeeper.sv
module secs_timekeeper
  import secs_pkg::*;
#(
  parameter int unsigned FRAC_W = SECS_FRAC_W_DEF,
  parameter int unsigned SEC_W  = SECS_SEC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              halt_i,
  input  logic              sec_wr_i,
  input  logic [SEC_W-1:0]  sec_wdata_i,
  input  logic              alarm_wr_i,
  input  logic [SEC_W-1:0]  alarm_wdata_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SEC_W-1:0]  alarm_sec_o,
  output logic              cmp_flag_o,
  output logic              irq_o,
  output logic              ovf_o
);
  logic rst_n_int;
  logic [SEC_W-1:0] sec_w;

  secs_rst_sync #(.STAGES(SECS_SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  secs_count #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .adv_i    (tick_i),
    .halt_i   (halt_i),
    .ld_i     (sec_wr_i),
    .ld_sec_i (sec_wdata_i),
    .frac_o   (frac_o),
    .sec_o    (sec_w),
    .ovf_o    (ovf_o)
  );

  secs_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .sec_i    (sec_w),
    .wr_i     (alarm_wr_i),
    .wdata_i  (alarm_wdata_i),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .alarm_o  (alarm_sec_o),
    .flag_o   (cmp_flag_o),
    .irq_o    (irq_o)
  );

  assign sec_o = sec_w;
endmodule

// File: tb/secs_timekeeper_bench.sv
module secs_timekeeper_bench;
  localparam int FW = 15;
  localparam int SW = 32;
  localparam longint unsigned CNT_MAX = (64'd1 << (FW + SW)) - 64'd1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          tick, halt, sec_wr, alm_wr, flag_clr, irq_en;
  logic [SW-1:0] sec_wdata, alm_wdata;
  logic [SW-1:0] sec_o, alarm_sec_o;
  logic [FW-1:0] frac_o;
  logic          cmp_flag_o, irq_o, ovf_o;

  secs_timekeeper u_secs_timekeeper (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .halt_i(halt),
    .sec_wr_i(sec_wr), .sec_wdata_i(sec_wdata),
    .alarm_wr_i(alm_wr), .alarm_wdata_i(alm_wdata),
    .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .sec_o(sec_o), .frac_o(frac_o), .alarm_sec_o(alarm_sec_o),
    .cmp_flag_o(cmp_flag_o), .irq_o(irq_o), .ovf_o(ovf_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference: one flat count, alarm and flag state.
  longint unsigned m_cnt;
  logic [SW-1:0]   m_alm;
  bit              m_flag, m_prev, m_ovf, m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_alm = '1; m_flag = 0; m_prev = 0; m_ovf = 0;
    end else begin
      m_hit = (m_alm != '1) && (m_alm == SW'(m_cnt >> FW));
      if (m_hit && !m_prev) m_flag = 1;
      else if (flag_clr)    m_flag = 0;
      m_prev = m_hit;
      m_ovf  = 0;
      if (sec_wr) m_cnt = longint'(sec_wdata) << FW;
      else if (tick && !halt) begin
        if (m_cnt == CNT_MAX) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (alm_wr) m_alm = alm_wdata;
    end
  end

  task automatic check(string what, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("sec",   sec_o,       m_cnt >> FW);
      check("frac",  frac_o,      m_cnt & ((64'd1 << FW) - 1));
      check("alarm", alarm_sec_o, m_alm);
      check("flag",  cmp_flag_o,  m_flag);
      check("irq",   irq_o,       m_flag && irq_en);
      check("ovf",   ovf_o,       m_ovf);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk); #1;
      sec_wr = 0; alm_wr = 0; flag_clr = 0;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired during %s", cur_req);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; halt = 0; sec_wr = 0; alm_wr = 0; flag_clr = 0;
    irq_en = 0; sec_wdata = '0; alm_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1"; cyc(5);            // reset state held with idle inputs

    cur_req = "R2"; tick = 1; cyc(33000);  // fraction carry into seconds
    for (int i = 0; i < 3000; i++) begin tick = (i % 3 == 0); cyc(1); end
    tick = 0;

    cur_req = "R3"; tick = 1;
    sec_wdata = 32'd5; sec_wr = 1; cyc(1);  // load with a tick in the same cycle
    cyc(100); tick = 0;

    cur_req = "R4"; halt = 1; tick = 1; cyc(200);
    sec_wdata = 32'd7; sec_wr = 1; cyc(1);  // load accepted while halted
    cyc(20); halt = 0; cyc(10); tick = 0;

    cur_req = "R5"; alm_wdata = 32'd40; alm_wr = 1; cyc(1); cyc(3);

    cur_req = "R6"; sec_wdata = 32'd40; sec_wr = 1; cyc(1); cyc(10);
    cur_req = "R8"; irq_en = 1; cyc(3); irq_en = 0; cyc(2); irq_en = 1;
    cur_req = "R7"; flag_clr = 1; cyc(1); cyc(3);

    cur_req = "R6"; alm_wdata = 32'd51; alm_wr = 1; cyc(1);
    sec_wdata = 32'd50; sec_wr = 1; cyc(1);
    tick = 1; cyc(32800); tick = 0;     // natural crossing of the alarm
    flag_clr = 1; cyc(1); cyc(2);

    cur_req = "R7"; alm_wdata = 32'd60; alm_wr = 1; cyc(1);
    sec_wdata = 32'd60; sec_wr = 1; cyc(1);
    flag_clr = 1; cyc(1);               // clear meets a new match: set wins
    cyc(4);
    flag_clr = 1; cyc(1); cyc(3);

    cur_req = "R10"; alm_wdata = '1; alm_wr = 1; cyc(1);
    sec_wdata = '1; sec_wr = 1; cyc(1); cyc(10);

    cur_req = "R9"; tick = 1; cyc(32800); tick = 0; cyc(5);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule